// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is the serial front end of a small bank of 8-bit configuration registers. It watches the two bus lines and recognises START, STOP and repeated START. It answers a 7-bit device address whose least significant bit comes from a strap input. A write carries one register-address byte and then any number of data bytes. A read returns the content of the register that the pointer currently selects.

The pointer never moves by itself. Every data byte in a burst, whether written or read, targets the same register. The pointer is also kept across a STOP. A host can therefore set the pointer in one transaction, release the bus, and read the selected register in a later transaction that carries only the device address with the read bit.

SCL and SDA each pass through a two-flop synchronizer and a two-sample agreement filter before any decoding. SDA is driven open-drain: the block only reports when it pulls the line low.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the registers at 0x00, 0x01 and 0x05 hold 0xFF. Those at 0x02 to 0x04, 0x06 to 0x0A and 0xAB hold 0x00. SDA is released (sda_oe_o = 0).
- R2: The device address is {DEV_HI, addr_strap_i}, with DEV_HI defaulting to 6'b010000. Only a matching address byte is acknowledged. After a mismatch SDA stays released until the next START.
- R3: A write is the address byte with R/W = 0, then a register-address byte, then data bytes. Each byte is acknowledged by pulling SDA low during the ninth clock, and each data byte is stored in the selected register.
- R4: The pointer never increments. Every data byte of a write burst lands in the same register, and every byte of a read burst returns the same register.
- R5: The pointer survives a STOP. A later transaction with R/W = 1 reads the register that the last register-address byte selected.
- R6: Addresses outside 0x00 to 0x0A and 0xAB are acknowledged, read as 0x00, and writes to them change no register.
- R7: A repeated START ends the current transfer and starts a new address phase, so a write of the pointer followed by Sr and a read returns the selected register.
- R8: When the master NACKs a read byte, the slave releases SDA and drives nothing more until the next STOP or START.
- R9: A pulse of a single clock cycle on SCL or SDA is ignored. In particular, such a pulse while SCL is high is not taken as START or STOP.
- R10: Read data bits are placed on SDA only while SCL is low, and SDA is held stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap that sets bit 0 of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a one-cycle pulse on SDA while SCL is high, in the middle of a data byte. A filter that let it through would see a false START or STOP and drop the write. The bench makes this pulse with a dedicated bit task that dips SDA for exactly one clock inside the high phase of a data bit. It then reads the register back to prove that the byte landed. Other cases reach deep states through ordinary traffic: a master NACK followed by further clocking, and a pointer set in one transaction and read in the next.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WR, ST_RD, ST_MACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) filt_o[i] <= 1'b1;
      else if (sync_q[i] == hist_q[i]) filt_o[i] <= sync_q[i];
    end

    // R9: output moves only after two agreeing samples of the new level
    p_filter_r9: assert property (@(posedge clk) disable iff (rst)
      (filt_o[i] != $past(filt_o[i])) |->
        ($past(sync_q[i]) == filt_o[i] && $past(hist_q[i]) == filt_o[i]));
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int              DW        = 8,
  parameter int              AW        = 8,
  parameter int              LOW_CNT   = 11,
  parameter logic [AW-1:0]   HIGH_ADDR = 8'hAB,
  parameter logic [LOW_CNT:0] ONES_MASK = 12'h023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int N  = LOW_CNT + 1;
  localparam int IW = $clog2(N);

  logic [DW-1:0] mem [N];
  logic          hit;
  logic [IW-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr_i < AW'(LOW_CNT)) begin
      hit = 1'b1;
      idx = IW'(addr_i);
    end else if (addr_i == HIGH_ADDR) begin
      hit = 1'b1;
      idx = IW'(N - 1);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) mem[i] <= ONES_MASK[i] ? '1 : '0;
      else if (we_i && hit && idx == IW'(i)) mem[i] <= wdata_i;
    end

    // R6: an entry moves only when a write hits exactly that entry
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(we_i && hit && idx == IW'(i)) |=> $stable(mem[i]));
  end

  assign rdata_o = hit ? mem[idx] : '0;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_rf_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          AW     = 8,
  parameter logic [5:0]  DEV_HI = 6'b010000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          strap_i,
  output logic          sda_oe_o,
  output logic          rf_we_o,
  output logic [AW-1:0] rf_addr_o,
  output logic [DW-1:0] rf_wdata_o,
  input  logic [DW-1:0] rf_rdata_i
);
  localparam int CW = $clog2(DW + 1);

  slv_state_e    state;
  logic          scl_d, sda_d;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg, tx;
  logic [AW-1:0] ptr;
  logic          in_ack, mack_ok;

  logic start_det, stop_det, scl_rise, scl_fall, byte_done, dev_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign start_det = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_det  = scl_i & scl_d & ~sda_d & sda_i;
  assign scl_rise  = scl_i & ~scl_d;
  assign scl_fall  = ~scl_i & scl_d;
  assign byte_done = scl_fall && (bit_cnt == CW'(DW)) && !in_ack;
  assign dev_match = (shreg[DW-1:1] == {DEV_HI, strap_i});

  assign rf_we_o    = (state == ST_WR) && byte_done && !start_det && !stop_det;
  assign rf_addr_o  = ptr;
  assign rf_wdata_o = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      in_ack   <= 1'b0;
      mack_ok  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_REG, ST_WR: begin
          if (scl_rise && !in_ack) begin
            shreg   <= {shreg[DW-2:0], sda_i};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && in_ack) begin
            in_ack   <= 1'b0;
            bit_cnt  <= '0;
            sda_oe_o <= 1'b0;
            if (state == ST_ADDR) begin
              if (shreg[0]) begin
                state    <= ST_RD;
                tx       <= rf_rdata_i;
                sda_oe_o <= ~rf_rdata_i[DW-1];
              end else begin
                state <= ST_REG;
              end
            end else begin
              state <= ST_WR;
            end
          end else if (byte_done) begin
            if (state == ST_ADDR && !dev_match) begin
              state <= ST_IDLE;
            end else begin
              in_ack   <= 1'b1;
              sda_oe_o <= 1'b1;
              if (state == ST_REG) ptr <= shreg;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == CW'(DW)) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_MACK;
            end else begin
              tx       <= {tx[DW-2:0], 1'b0};
              sda_oe_o <= ~tx[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_i;
          end else if (scl_fall) begin
            if (mack_ok) begin
              state    <= ST_RD;
              tx       <= rf_rdata_i;
              sda_oe_o <= ~rf_rdata_i[DW-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10: SDA drive is frozen through a steady high SCL phase
  p_oe_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_i && scl_d && !start_det && !stop_det) |=> $stable(sda_oe_o));

  // R8 / R2: an idle slave never holds the line
  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe_o);

  // R3: bit counter never passes one byte
  p_bitcnt_r3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(DW));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         DW     = 8,
  parameter int         AW     = 8,
  parameter logic [5:0] DEV_HI = 6'b010000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_strap_i,
  output logic sda_oe_o
);
  logic [1:0]    filt;
  logic          rf_we;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata, rf_rdata;

  i2c_line_filter #(.W(2)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .raw_i  ({scl_i, sda_i}),
    .filt_o (filt)
  );

  i2c_slave_fsm #(.DW(DW), .AW(AW), .DEV_HI(DEV_HI)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (filt[1]),
    .sda_i      (filt[0]),
    .strap_i    (addr_strap_i),
    .sda_oe_o   (sda_oe_o),
    .rf_we_o    (rf_we),
    .rf_addr_o  (rf_addr),
    .rf_wdata_o (rf_wdata),
    .rf_rdata_i (rf_rdata)
  );

  cfg_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we_i    (rf_we),
    .addr_i  (rf_addr),
    .wdata_i (rf_wdata),
    .rdata_o (rf_rdata)
  );
endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV0 = 7'b0100000;
  localparam logic [6:0] DEV1 = 7'b0100001;
  // {mode, reg, wdata, expected}: mode 0 = Sr read, 1 = read after STOP
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'h00, 8'h5A, 8'h5A},
    {8'd1, 8'h01, 8'h3C, 8'h3C},
    {8'd0, 8'h0A, 8'hA5, 8'hA5},
    {8'd1, 8'hAB, 8'h81, 8'h81},
    {8'd0, 8'h30, 8'h77, 8'h00},
    {8'd1, 8'h0B, 8'h12, 8'h00},
    {8'd0, 8'hAA, 8'hFF, 8'h00},
    {8'd1, 8'h02, 8'hC3, 8'hC3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0, errors = 0, unstable = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave dut_i (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_bus),
    .addr_strap_i (strap), .sda_oe_o (sda_oe)
  );

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(logic b, logic glitch);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
    if (glitch) begin
      sda_m = ~b; wq(1); sda_m = b; wq(Q - 1);
    end else wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    logic s0;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(6);
    s0 = sda_bus; wq(Q - 6);
    b = sda_bus; wq(Q - 1);
    if (sda_bus !== s0) unstable++;
    wq(1); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack, input logic glitch = 1'b0);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i], glitch && i == 2);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rbyte(logic send_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~send_ack, 1'b0);
  endtask

  task automatic wr_reg(logic [7:0] r, logic [7:0] d);
    logic a;
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(r, a); wbyte(d, a); bstop();
  endtask

  task automatic rd_comb(logic [7:0] r, output logic [7:0] d);
    logic a;
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(r, a);
    bstart(); wbyte({DEV0, 1'b1}, a); rbyte(1'b0, d); bstop();
  endtask

  task automatic set_ptr(logic [7:0] r);
    logic a;
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(r, a); bstop();
  endtask

  task automatic rd_cur(output logic [7:0] d);
    logic a;
    bstart(); wbyte({DEV0, 1'b1}, a); rbyte(1'b0, d); bstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic a, a2, a3;
    wq(5); rst = 1'b0; wq(5);
    chk("R1 sda released after reset", {7'd0, sda_oe}, 8'h00);

    // vector walk: R3 writes, R5 and R7 read paths, R6 unimplemented
    for (int v = 0; v < 8; v++) begin
      wr_reg(VEC[v][23:16], VEC[v][15:8]);
      if (VEC[v][31:24] == 8'd0) rd_comb(VEC[v][23:16], d);
      else begin set_ptr(VEC[v][23:16]); wq(40); rd_cur(d); end
      chk($sformatf("R3 R5 R6 R7 vector %0d", v), d, VEC[v][7:0]);
    end

    // R1: defaults after a fresh reset
    wq(2); rst = 1'b1; wq(4); rst = 1'b0; wq(4);
    rd_comb(8'h00, d); chk("R1 reg00", d, 8'hFF);
    rd_comb(8'h01, d); chk("R1 reg01", d, 8'hFF);
    rd_comb(8'h05, d); chk("R1 reg05", d, 8'hFF);
    rd_comb(8'h02, d); chk("R1 reg02", d, 8'h00);
    rd_comb(8'hAB, d); chk("R1 regAB", d, 8'h00);

    // R2: wrong strap bit is not answered, nor are later bytes
    bstart(); wbyte({DEV1, 1'b0}, a); wbyte(8'h03, a2); bstop();
    chk("R2 mismatch addr nack", {7'd0, a}, 8'h00);
    chk("R2 silent after mismatch", {7'd0, a2}, 8'h00);
    strap = 1'b1; wq(4);
    bstart(); wbyte({DEV1, 1'b0}, a); wbyte(8'h03, a2); wbyte(8'h44, a3); bstop();
    chk("R2 strap-selected addr ack", {7'd0, a}, 8'h01);
    strap = 1'b0; wq(4);
    rd_comb(8'h03, d); chk("R2 R3 write via strap addr", d, 8'h44);

    // R4: burst write lands in one register, neighbour untouched
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(8'h04, a);
    wbyte(8'h11, a); wbyte(8'h22, a2); wbyte(8'h33, a3); bstop();
    chk("R3 burst data acked", {7'd0, a & a2 & a3}, 8'h01);
    rd_comb(8'h04, d); chk("R4 burst write last wins", d, 8'h33);
    rd_comb(8'h05, d); chk("R4 next register untouched", d, 8'hFF);

    // R4: burst read repeats the register
    wr_reg(8'h06, 8'h6E);
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(8'h06, a);
    bstart(); wbyte({DEV0, 1'b1}, a); rbyte(1'b1, d); rbyte(1'b0, d2); bstop();
    chk("R4 burst read byte0", d, 8'h6E);
    chk("R4 burst read byte1", d2, 8'h6E);

    // R8: after master NACK the slave drives nothing
    bstart(); wbyte({DEV0, 1'b1}, a); rbyte(1'b0, d); rbyte(1'b0, d2); bstop();
    chk("R8 byte before nack", d, 8'h6E);
    chk("R8 nothing driven after nack", d2, 8'hFF);

    // R5: pointer kept across STOP and idle time
    wr_reg(8'h07, 8'h9D);
    set_ptr(8'h07); wq(200); rd_cur(d); chk("R5 pointer after stop", d, 8'h9D);
    rd_cur(d); chk("R5 pointer kept after read", d, 8'h9D);

    // R9: one-cycle SDA dip while SCL high inside a data byte
    bstart(); wbyte({DEV0, 1'b0}, a); wbyte(8'h09, a); wbyte(8'h5C, a2, 1'b1); bstop();
    chk("R9 glitched byte acked", {7'd0, a2}, 8'h01);
    rd_comb(8'h09, d); chk("R9 glitch ignored", d, 8'h5C);

    // R6: unimplemented write leaves neighbours alone
    wr_reg(8'h0B, 8'hEE);
    rd_comb(8'h0A, d); chk("R6 reg0A unchanged", d, 8'h00);
    rd_comb(8'hAB, d); chk("R6 regAB unchanged", d, 8'h00);

    chk("R10 sda stable while scl high", 8'(unstable), 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule